// File: doc/BRIEF.md
# DMA Interrupt and Error Status Unit

This block handles interrupts and error monitoring for a DMA controller that runs many jobs. When a job finishes, the block is told which job it was and whether that job asked for an interrupt. It also watches four error sources: a transfer whose destination points back into the controller's own register space or local RAM, an error response on the bus master port, a hardware start request for a job that is still running, and a slave-port write that is not a full 32-bit word.

Two status registers record these events. Job status has one bit per job. Error status has one bit per error class. Software clears bits in either register by writing 1 to them. Each register drives its own active-high interrupt line. The line gives a pulse of bounded length rather than a level, so an edge- or level-sensitive interrupt collector can use it directly. A nominal pulse lasts three cycles. Events that overlap a pulse stretch it, but never past five cycles.

Top module: `dma_irq_unit`

## Requirements
- R1: After a synchronous reset, both status registers read zero and both interrupt lines are low.
- R2: A job-finished event with its interrupt enable high sets bit `job_done_id` of `job_status` in the following cycle. With the enable low, no status bit changes and no pulse follows.
- R3: A status-setting event while the pulse line is idle raises that line in the next cycle, the same cycle the status bit appears. The line stays high for exactly 3 cycles.
- R4: An event arriving while the pulse has been high for k cycles stretches the total pulse length to min(k+3, 5) if that is longer than the current length. A pulse is never longer than 5 cycles.
- R5: If an event arrives when k+3 exceeds 5, the pulse ends at 5 cycles. The line then stays low for exactly one cycle, and a fresh 3-cycle pulse follows.
- R6: Writing with the clear strobe high clears exactly the status bits whose mask bits are 1. All other bits are left unchanged.
- R7: If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: Error status bit 0 is set when a destination address lies inside the register window [0x4000_0000, +0x1000) or the RAM window [0x4001_0000, +0x4000). Addresses outside both windows set nothing.
- R9: A bus master error response sets error status bit 1. Several error classes in one cycle set all their bits and produce a single pulse.
- R10: A hardware start for a job whose busy flag is set sets error status bit 2. A start for an idle job sets nothing.
- R11: A slave-port write with a size code other than 3'b010 (32-bit word) sets error status bit 3. A word-sized write sets nothing.
- R12: While the global error interrupt enable is low, no error status bit is set and no error pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_irq_en | input | 1 | Global enable for error recording and the error pulse |
| job_done_valid | input | 1 | A job finished this cycle |
| job_done_id | input | 5 | Number of the finished job |
| job_done_ien | input | 1 | Interrupt enable of the finished job |
| hw_start_valid | input | 1 | Hardware start request this cycle |
| hw_start_id | input | 5 | Job addressed by the hardware start |
| job_busy | input | 32 | Per-job running flags |
| dst_valid | input | 1 | A destination address is being programmed |
| dst_addr | input | 32 | Destination address to check |
| mst_resp_err | input | 1 | Error response on the bus master port |
| slv_wr_valid | input | 1 | Write on the slave port |
| slv_wr_size | input | 3 | Transfer size code of that write |
| job_clr_we | input | 1 | Clear strobe for job status |
| job_clr_mask | input | 32 | Write-one-to-clear mask for job status |
| err_clr_we | input | 1 | Clear strobe for error status |
| err_clr_mask | input | 4 | Write-one-to-clear mask for error status |
| job_status | output | 32 | Job-finished status bits |
| err_status | output | 4 | Error status bits |
| job_irq | output | 1 | Job-finished interrupt pulse |
| err_irq | output | 1 | Error interrupt pulse |

## Verification
A corrupted pulse counter shows up as a wrong high-run length on `job_irq` or `err_irq`. A lost pending flag shows up as a missing second pulse one cycle after a five-cycle run. Both appear within about ten cycles of the triggering event. A bad set/clear priority or a bad window compare leaves a wrong bit in a status register one cycle after the stimulus, where it stays until cleared. The bench therefore compares the status registers against a running model after every stimulus, and matches every observed pulse width against a queue of expected widths.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ERR_NUM      = 4;
  localparam int ERR_DST_BIT  = 0;
  localparam int ERR_BUS_BIT  = 1;
  localparam int ERR_RST_BIT  = 2;
  localparam int ERR_SLV_BIT  = 3;
  localparam logic [2:0] SIZE_WORD = 3'b010;
  typedef logic [ERR_NUM-1:0] err_vec_t;
endpackage

// File: rtl/dma_addr_window.sv
module dma_addr_window #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = 'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] offs;
  always_comb begin
    offs = addr - BASE;
    hit  = (addr >= BASE) && (offs < SIZE);
  end
endmodule

// File: rtl/dma_err_detect.sv
module dma_err_detect
  import dma_irq_pkg::*;
#(
  parameter int NUM_JOBS = 32,
  parameter int JOB_W    = $clog2(NUM_JOBS),
  parameter int ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] REG_SIZE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4001_0000,
  parameter logic [ADDR_W-1:0] RAM_SIZE = 32'h0000_4000
) (
  input  logic                dst_valid,
  input  logic [ADDR_W-1:0]   dst_addr,
  input  logic                mst_resp_err,
  input  logic                hw_start_valid,
  input  logic [JOB_W-1:0]    hw_start_id,
  input  logic [NUM_JOBS-1:0] job_busy,
  input  logic                slv_wr_valid,
  input  logic [2:0]          slv_wr_size,
  output err_vec_t            err_evt
);
  localparam int NWIN = 2;
  localparam logic [NWIN-1:0][ADDR_W-1:0] WBASE = {RAM_BASE, REG_BASE};
  localparam logic [NWIN-1:0][ADDR_W-1:0] WSIZE = {RAM_SIZE, REG_SIZE};

  logic [NWIN-1:0] win_hit;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    dma_addr_window #(
      .ADDR_W(ADDR_W), .BASE(WBASE[w]), .SIZE(WSIZE[w])
    ) u_win (
      .addr(dst_addr),
      .hit (win_hit[w])
    );
  end

  always_comb begin
    err_evt              = '0;
    err_evt[ERR_DST_BIT] = dst_valid && (|win_hit);
    err_evt[ERR_BUS_BIT] = mst_resp_err;
    err_evt[ERR_RST_BIT] = hw_start_valid && job_busy[hw_start_id];
    err_evt[ERR_SLV_BIT] = slv_wr_valid && (slv_wr_size != SIZE_WORD);
  end
endmodule

// File: rtl/dma_w1c_status.sv
module dma_w1c_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] stat_q;
  logic [W-1:0] keep;

  always_comb keep = clr_we ? (stat_q & ~clr_mask) : stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= keep | set_vec;
  end

  assign status = stat_q;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((status & $past(clr_mask & ~set_vec)) == '0));

  assert_untouched_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((status ^ $past(status)) & ~$past(set_vec)
               & ~($past(clr_mask) & {W{$past(clr_we)}})) == '0));
endmodule

// File: rtl/dma_irq_pulse.sv
module dma_irq_pulse #(
  parameter int PULSE_LEN = 3,
  parameter int PULSE_MAX = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic irq
);
  localparam int CW = $clog2(PULSE_MAX + PULSE_LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(PULSE_LEN);
  localparam logic [CW-1:0] MAX_C = CW'(PULSE_MAX);

  logic          act_q, pend_q;
  logic [CW-1:0] el_q, len_q;
  logic [CW-1:0] reach, want;
  logic          late;

  always_comb begin
    reach = el_q + LEN_C;
    want  = len_q;
    late  = 1'b0;
    if (trig) begin
      if (reach > MAX_C) begin
        want = MAX_C;
        late = 1'b1;
      end else if (reach > len_q) begin
        want = reach;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      el_q   <= '0;
      len_q  <= '0;
    end else if (!act_q) begin
      if (trig || pend_q) begin
        act_q <= 1'b1;
        el_q  <= CW'(1);
        len_q <= LEN_C;
      end
      pend_q <= 1'b0;
    end else begin
      len_q <= want;
      if (late) pend_q <= 1'b1;
      if (el_q >= want) begin
        act_q <= 1'b0;
        el_q  <= '0;
      end else begin
        el_q <= el_q + CW'(1);
      end
    end
  end

  assign irq = act_q;

  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    (trig && !irq) |=> irq);

  assert_min_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |=> irq);

  assert_cap_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> (el_q >= CW'(1) && el_q <= MAX_C && len_q <= MAX_C));

  assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(irq) && pend_q) |=> irq);
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
  import dma_irq_pkg::*;
#(
  parameter int NUM_JOBS  = 32,
  parameter int JOB_W     = $clog2(NUM_JOBS),
  parameter int ADDR_W    = 32,
  parameter int PULSE_LEN = 3,
  parameter int PULSE_MAX = 5,
  parameter logic [ADDR_W-1:0] REG_BASE = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] REG_SIZE = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] RAM_BASE = 32'h4001_0000,
  parameter logic [ADDR_W-1:0] RAM_SIZE = 32'h0000_4000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                err_irq_en,
  input  logic                job_done_valid,
  input  logic [JOB_W-1:0]    job_done_id,
  input  logic                job_done_ien,
  input  logic                hw_start_valid,
  input  logic [JOB_W-1:0]    hw_start_id,
  input  logic [NUM_JOBS-1:0] job_busy,
  input  logic                dst_valid,
  input  logic [ADDR_W-1:0]   dst_addr,
  input  logic                mst_resp_err,
  input  logic                slv_wr_valid,
  input  logic [2:0]          slv_wr_size,
  input  logic                job_clr_we,
  input  logic [NUM_JOBS-1:0] job_clr_mask,
  input  logic                err_clr_we,
  input  logic [ERR_NUM-1:0]  err_clr_mask,
  output logic [NUM_JOBS-1:0] job_status,
  output logic [ERR_NUM-1:0]  err_status,
  output logic                job_irq,
  output logic                err_irq
);
  logic [NUM_JOBS-1:0] job_set;
  err_vec_t            err_evt, err_set;

  for (genvar j = 0; j < NUM_JOBS; j++) begin : g_dec
    assign job_set[j] = job_done_valid && job_done_ien
                        && (job_done_id == JOB_W'(j));
  end

  dma_err_detect #(
    .NUM_JOBS(NUM_JOBS), .JOB_W(JOB_W), .ADDR_W(ADDR_W),
    .REG_BASE(REG_BASE), .REG_SIZE(REG_SIZE),
    .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE)
  ) u_det (
    .dst_valid     (dst_valid),
    .dst_addr      (dst_addr),
    .mst_resp_err  (mst_resp_err),
    .hw_start_valid(hw_start_valid),
    .hw_start_id   (hw_start_id),
    .job_busy      (job_busy),
    .slv_wr_valid  (slv_wr_valid),
    .slv_wr_size   (slv_wr_size),
    .err_evt       (err_evt)
  );

  assign err_set = err_irq_en ? err_evt : '0;

  dma_w1c_status #(.W(NUM_JOBS)) u_job_st (
    .clk(clk), .rst(rst), .set_vec(job_set),
    .clr_we(job_clr_we), .clr_mask(job_clr_mask), .status(job_status)
  );

  dma_w1c_status #(.W(ERR_NUM)) u_err_st (
    .clk(clk), .rst(rst), .set_vec(err_set),
    .clr_we(err_clr_we), .clr_mask(err_clr_mask), .status(err_status)
  );

  dma_irq_pulse #(.PULSE_LEN(PULSE_LEN), .PULSE_MAX(PULSE_MAX)) u_job_pg (
    .clk(clk), .rst(rst), .trig(|job_set), .irq(job_irq)
  );

  dma_irq_pulse #(.PULSE_LEN(PULSE_LEN), .PULSE_MAX(PULSE_MAX)) u_err_pg (
    .clk(clk), .rst(rst), .trig(|err_set), .irq(err_irq)
  );

  assert_job_set_R2: assert property (@(posedge clk) disable iff (rst)
    (job_done_valid && job_done_ien) |=> job_status[$past(job_done_id)]);

  assert_job_gate_R2: assert property (@(posedge clk) disable iff (rst)
    !(job_done_valid && job_done_ien) |=> ((job_status & ~$past(job_status)) == '0));

  assert_err_gate_R12: assert property (@(posedge clk) disable iff (rst)
    !err_irq_en |=> ((err_status & ~$past(err_status)) == '0));

  assert_slv_size_R11: assert property (@(posedge clk) disable iff (rst)
    (err_irq_en && slv_wr_valid && slv_wr_size != SIZE_WORD) |=> err_status[ERR_SLV_BIT]);

  assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
    (err_irq_en && hw_start_valid && job_busy[hw_start_id]) |=> err_status[ERR_RST_BIT]);

  assert_bus_R9: assert property (@(posedge clk) disable iff (rst)
    (err_irq_en && mst_resp_err) |=> err_status[ERR_BUS_BIT]);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (job_status == '0 && err_status == '0 && !job_irq && !err_irq));
endmodule

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_irq_en = 1'b0;
  logic        job_done_valid = 1'b0;
  logic [4:0]  job_done_id = '0;
  logic        job_done_ien = 1'b0;
  logic        hw_start_valid = 1'b0;
  logic [4:0]  hw_start_id = '0;
  logic [31:0] job_busy = '0;
  logic        dst_valid = 1'b0;
  logic [31:0] dst_addr = '0;
  logic        mst_resp_err = 1'b0;
  logic        slv_wr_valid = 1'b0;
  logic [2:0]  slv_wr_size = 3'b010;
  logic        job_clr_we = 1'b0;
  logic [31:0] job_clr_mask = '0;
  logic        err_clr_we = 1'b0;
  logic [3:0]  err_clr_mask = '0;
  logic [31:0] job_status;
  logic [3:0]  err_status;
  logic        job_irq, err_irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_job = '0;
  logic [3:0]  exp_err = '0;
  int    jq[$];  string jtag[$];
  int    eq[$];  string etag[$];
  int    jrun = 0, erun = 0;

  always #2.5 clk = ~clk;

  dma_irq_unit uut (
    .clk(clk), .rst(rst), .err_irq_en(err_irq_en),
    .job_done_valid(job_done_valid), .job_done_id(job_done_id),
    .job_done_ien(job_done_ien), .hw_start_valid(hw_start_valid),
    .hw_start_id(hw_start_id), .job_busy(job_busy), .dst_valid(dst_valid),
    .dst_addr(dst_addr), .mst_resp_err(mst_resp_err),
    .slv_wr_valid(slv_wr_valid), .slv_wr_size(slv_wr_size),
    .job_clr_we(job_clr_we), .job_clr_mask(job_clr_mask),
    .err_clr_we(err_clr_we), .err_clr_mask(err_clr_mask),
    .job_status(job_status), .err_status(err_status),
    .job_irq(job_irq), .err_irq(err_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: measures every high run and pops the expected width
  always @(negedge clk) begin
    if (!rst) begin
      if (job_irq) jrun++;
      else if (jrun > 0) begin
        if (jq.size() == 0) chk(1'b0, "R2 unexpected job pulse", jrun, 0);
        else chk(jrun == jq[0], jtag[0], jrun, jq[0]);
        if (jq.size() > 0) begin void'(jq.pop_front()); void'(jtag.pop_front()); end
        jrun = 0;
      end
      if (err_irq) erun++;
      else if (erun > 0) begin
        if (eq.size() == 0) chk(1'b0, "R12 unexpected err pulse", erun, 0);
        else chk(erun == eq[0], etag[0], erun, eq[0]);
        if (eq.size() > 0) begin void'(eq.pop_front()); void'(etag.pop_front()); end
        erun = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string tag);
    chk(job_status == exp_job, {tag, " job_status"}, job_status, exp_job);
    chk(err_status == exp_err, {tag, " err_status"}, err_status, exp_err);
  endtask

  // drive a burst of consecutive job completions starting at id
  task automatic jobs(input int first, input int cnt, input bit ien);
    for (int i = 0; i < cnt; i++) begin
      job_done_valid = 1'b1; job_done_id = 5'(first + i); job_done_ien = ien;
      if (ien) exp_job[first + i] = 1'b1;
      @(negedge clk);
    end
    job_done_valid = 1'b0; job_done_ien = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_regs("R1");
    chk(!job_irq && !err_irq, "R1 irq low", {job_irq, err_irq}, 0);

    // R2 / R3: single enabled completion
    jq.push_back(3); jtag.push_back("R3 single pulse width");
    jobs(5, 1, 1'b1);
    check_regs("R2 set");
    chk(job_irq == 1'b1, "R3 irq rises with status", job_irq, 1);
    idle(10);

    // R2: disabled completion does nothing
    jobs(7, 1, 1'b0);
    check_regs("R2 disabled");
    chk(job_irq == 1'b0, "R2 no pulse", job_irq, 0);
    idle(10);

    // R4: two and three consecutive events
    jq.push_back(4); jtag.push_back("R4 two-event stretch");
    jobs(1, 2, 1'b1);
    idle(10);
    jq.push_back(5); jtag.push_back("R4 three-event cap");
    jobs(20, 3, 1'b1);
    idle(10);

    // R5: four consecutive events -> 5, one low, 3
    jq.push_back(5); jtag.push_back("R5 capped pulse");
    jq.push_back(3); jtag.push_back("R5 follow-up pulse");
    jobs(10, 4, 1'b1);
    idle(6);
    check_regs("R4 R5 status");
    idle(6);

    // R6: clear one bit
    job_clr_we = 1'b1; job_clr_mask = 32'h0000_0020; exp_job[5] = 1'b0;
    @(negedge clk);
    job_clr_we = 1'b0; job_clr_mask = '0;
    check_regs("R6 clear");

    // R7: set and clear same bit same cycle
    jq.push_back(3); jtag.push_back("R7 pulse");
    job_clr_we = 1'b1; job_clr_mask = 32'h0000_0002;
    jobs(1, 1, 1'b1);
    job_clr_we = 1'b0; job_clr_mask = '0;
    check_regs("R7 set wins");
    idle(10);

    // errors enabled
    err_irq_en = 1'b1;
    // R8 register window
    eq.push_back(3); etag.push_back("R8 pulse");
    dst_valid = 1'b1; dst_addr = 32'h4000_0ffc; exp_err[0] = 1'b1;
    @(negedge clk); dst_valid = 1'b0;
    check_regs("R8 reg window");
    idle(10);
    err_clr_we = 1'b1; err_clr_mask = 4'b0001; exp_err = '0;
    @(negedge clk); err_clr_we = 1'b0; err_clr_mask = '0;
    check_regs("R6 err clear");
    // R8 outside both windows
    dst_valid = 1'b1; dst_addr = 32'h4000_1000;
    @(negedge clk); dst_addr = 32'h4001_4000;
    @(negedge clk); dst_valid = 1'b0;
    check_regs("R8 outside");
    idle(6);
    // R8 last byte of RAM window
    eq.push_back(3); etag.push_back("R8 ram pulse");
    dst_valid = 1'b1; dst_addr = 32'h4001_3fff; exp_err[0] = 1'b1;
    @(negedge clk); dst_valid = 1'b0;
    check_regs("R8 ram window");
    idle(10);

    // R9 bus error together with bad slave write -> single pulse
    eq.push_back(3); etag.push_back("R9 combined pulse");
    mst_resp_err = 1'b1; slv_wr_valid = 1'b1; slv_wr_size = 3'b001;
    exp_err[1] = 1'b1; exp_err[3] = 1'b1;
    @(negedge clk); mst_resp_err = 1'b0; slv_wr_valid = 1'b0;
    check_regs("R9 R11 set");
    idle(10);
    err_clr_we = 1'b1; err_clr_mask = 4'b1111; exp_err = '0;
    @(negedge clk); err_clr_we = 1'b0; err_clr_mask = '0;

    // R11 word-size write is fine
    slv_wr_valid = 1'b1; slv_wr_size = 3'b010;
    @(negedge clk); slv_wr_valid = 1'b0;
    check_regs("R11 word ok");

    // R10 restart of idle job, then busy job
    job_busy = 32'h0000_0010;
    hw_start_valid = 1'b1; hw_start_id = 5'd6;
    @(negedge clk); hw_start_valid = 1'b0;
    check_regs("R10 idle start");
    idle(4);
    eq.push_back(3); etag.push_back("R10 pulse");
    hw_start_valid = 1'b1; hw_start_id = 5'd4; exp_err[2] = 1'b1;
    @(negedge clk); hw_start_valid = 1'b0;
    check_regs("R10 busy start");
    idle(10);
    err_clr_we = 1'b1; err_clr_mask = 4'b0100; exp_err = '0;
    @(negedge clk); err_clr_we = 1'b0; err_clr_mask = '0;

    // R12 enable off: everything at once
    err_irq_en = 1'b0;
    dst_valid = 1'b1; dst_addr = 32'h4000_0000; mst_resp_err = 1'b1;
    hw_start_valid = 1'b1; slv_wr_valid = 1'b1; slv_wr_size = 3'b000;
    @(negedge clk);
    dst_valid = 1'b0; mst_resp_err = 1'b0; hw_start_valid = 1'b0; slv_wr_valid = 1'b0;
    check_regs("R12 gated");
    chk(err_irq == 1'b0, "R12 no pulse", err_irq, 0);
    idle(10);

    chk(jq.size() == 0, "R3 missing job pulses", jq.size(), 0);
    chk(eq.size() == 0, "R12 missing err pulses", eq.size(), 0);
    finish_run();
  end
endmodule